// File: doc/BRIEF.md
# Sectored Write-Back Data Cache

This block is a direct-mapped data cache. Each line is cut into sectors, and all sectors of a line share one tag. Every sector keeps its own valid flag and its own dirty flag, so a line can sit in the cache with only some of its sectors present. The processor side takes one word read or write at a time. A read hit answers on the cycle after the request is taken. A miss holds the processor until the missing sector has been brought in.

Stores are kept in the cache and reach memory only when their line is replaced. A store that misses allocates the line and follows the same fill path as a load, then merges its bytes. On a miss, memory traffic is limited to the sector that was asked for. When a different tag displaces a line, only the sectors flagged dirty are written out. Clean or absent sectors cause no traffic.

The memory side is one valid/ready channel that carries a single word per beat, so a sector moves in as many beats as it holds words. For a read beat, memory returns the word in the same cycle as the handshake.

Top module: `sector_wb_cache`

## Requirements
- R1: A read that hits a present sector raises resp_valid on the cycle after req_valid and req_ready were both high, with the stored word on resp_rdata.
- R2: A byte address splits as follows: bits [1:0] are the byte offset and must be zero; bits [3:2] pick the word; bits [5:4] pick the sector; the next log2(LINES) bits pick the line; the remaining upper bits are the tag. Every memory beat address is built from these fields, with the word field set to the beat number.
- R3: When the tag matches but the addressed sector is absent, the cache issues exactly four read beats for that sector, at ascending word addresses. The other sectors of the line keep their contents and their valid flags.
- R4: A write hit merges req_wdata into the word under req_be, where bit n enables byte n (bits 8n+7 to 8n). It marks that sector dirty, causes no memory beat, and is acknowledged on resp_valid one cycle after acceptance.
- R5: A write miss first fills the addressed sector exactly as a read miss would, then merges the write. Writes never go straight to memory.
- R6: When a line is replaced, each dirty sector is written back as four write beats under the old tag, lowest sector first. Clean and absent sectors are not written.
- R7: Any number of writes to one sector before eviction produce a single four-beat writeback that holds the merged data.
- R8: After a replacement, the new line holds only the sector that was fetched. An access to any other sector of that line is a miss.
- R9: Replacing a line that has no dirty sector causes no write beat.
- R10: A memory beat completes only in a cycle where mem_valid and mem_ready are both high. While mem_ready is low, mem_valid, mem_addr, mem_write and mem_wdata stay unchanged.
- R11: Only one request is in flight. req_ready is high only when the cache is idle, and it is low in the cycle in which resp_valid is high.
- R12: After reset every line is invalid, req_ready is high, and no memory beat is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word-aligned byte address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| resp_valid | output | 1 | Load data or store acknowledge, one cycle |
| resp_rdata | output | DATA_W | Load data |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | 1 = writeback beat, 0 = fill beat |
| mem_addr | output | ADDR_W | Word address of the beat |
| mem_wdata | output | DATA_W | Writeback word |
| mem_rdata | input | DATA_W | Fill word, valid during a read handshake |

## Verification
The bench builds the cache with eight lines and keeps the default four sectors of four 32-bit words. With so few lines, three tags aimed at the same line index produce a steady stream of evictions. Those evictions hit lines in every mix of present, absent, clean and dirty sectors, which would need far longer runs with sixty-four lines. Memory readiness alternates between a stalling pattern and a free-running one, so beats are checked both while held and back to back.

// File: rtl/sector_cache_pkg.sv
package sector_cache_pkg;

  // Controller phases: idle, tag lookup, dirty-sector drain, sector fill
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_WBACK = 2'd2,
    ST_FILL  = 2'd3
  } ctl_state_t;

endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
  parameter int LINES   = 64,
  parameter int SECTORS = 4,
  parameter int TAG_W   = 20,
  localparam int IDX_W  = $clog2(LINES),
  localparam int SEC_W  = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [TAG_W-1:0]   rd_tag,
  output logic               rd_lvalid,
  output logic [SECTORS-1:0] rd_svalid,
  output logic [SECTORS-1:0] rd_sdirty,
  input  logic               inst_en,
  input  logic [TAG_W-1:0]   inst_tag,
  input  logic               setv_en,
  input  logic               setd_en,
  input  logic               clrd_en,
  input  logic [SEC_W-1:0]   op_sec
);

  logic [TAG_W-1:0]   tag_q    [LINES];
  logic               lval_q   [LINES];
  logic [SECTORS-1:0] sval_q   [LINES];
  logic [SECTORS-1:0] sdirty_q [LINES];

  assign rd_tag    = tag_q[rd_idx];
  assign rd_lvalid = lval_q[rd_idx];
  assign rd_svalid = sval_q[rd_idx];
  assign rd_sdirty = sdirty_q[rd_idx];

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[rd_idx] <= inst_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        lval_q[i]   <= 1'b0;
        sval_q[i]   <= '0;
        sdirty_q[i] <= '0;
      end
    end else if (inst_en) begin
      lval_q[rd_idx]   <= 1'b1;
      sval_q[rd_idx]   <= '0;
      sdirty_q[rd_idx] <= '0;
    end else begin
      if (setv_en) sval_q[rd_idx][op_sec] <= 1'b1;
      if (setd_en) sdirty_q[rd_idx][op_sec] <= 1'b1;
      if (clrd_en) sdirty_q[rd_idx][op_sec] <= 1'b0;
    end
  end

  AST_NO_DIRTY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    inst_en |-> (!lval_q[rd_idx] || sdirty_q[rd_idx] == '0))
    else $error("line replaced while dirty sectors remain"); // R6

  AST_WB_WAS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    clrd_en |-> sdirty_q[rd_idx][op_sec])
    else $error("writeback finished on a clean sector"); // R6

  AST_DIRTY_NEEDS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    setd_en |-> (lval_q[rd_idx] && sval_q[rd_idx][op_sec]))
    else $error("store merged into an absent sector"); // R4

endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int NB    = DATA_W / 8
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NB-1:0]     wr_be
);

  logic [DATA_W-1:0] word_q [DEPTH];

  assign rd_data = word_q[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_be[b]) word_q[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/sc_controller.sv
module sc_controller
  import sector_cache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LINES     = 64,
  parameter int SECTORS   = 4,
  parameter int SEC_WORDS = 4,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB),
  localparam int WRD_W = $clog2(SEC_WORDS),
  localparam int SEC_W = $clog2(SECTORS),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W - SEC_W - WRD_W - OFF_W,
  localparam int DS_AW = IDX_W + SEC_W + WRD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [NB-1:0]      req_be,
  output logic               resp_valid,
  output logic [DATA_W-1:0]  resp_rdata,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_write,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [IDX_W-1:0]   ts_idx,
  input  logic [TAG_W-1:0]   ts_tag,
  input  logic               ts_lvalid,
  input  logic [SECTORS-1:0] ts_svalid,
  input  logic [SECTORS-1:0] ts_sdirty,
  output logic               ts_inst_en,
  output logic [TAG_W-1:0]   ts_inst_tag,
  output logic               ts_setv,
  output logic               ts_setd,
  output logic               ts_clrd,
  output logic [SEC_W-1:0]   ts_sec,
  output logic [DS_AW-1:0]   ds_raddr,
  input  logic [DATA_W-1:0]  ds_rdata,
  output logic               ds_we,
  output logic [DS_AW-1:0]   ds_waddr,
  output logic [DATA_W-1:0]  ds_wdata,
  output logic [NB-1:0]      ds_wbe
);

  // ---- address arithmetic ----
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W+WRD_W+SEC_W +: IDX_W];
  endfunction

  function automatic logic [SEC_W-1:0] f_sec(input logic [ADDR_W-1:0] a);
    return a[OFF_W+WRD_W +: SEC_W];
  endfunction

  function automatic logic [WRD_W-1:0] f_wrd(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: WRD_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_join(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] i,
                                               input logic [SEC_W-1:0] s, input logic [WRD_W-1:0] w);
    return {t, i, s, w, {OFF_W{1'b0}}};
  endfunction

  // lowest-numbered set bit; drains dirty sectors in ascending order
  function automatic logic [SEC_W-1:0] f_first(input logic [SECTORS-1:0] m);
    logic [SEC_W-1:0] r;
    r = '0;
    for (int k = SECTORS - 1; k >= 0; k--) begin
      if (m[k]) r = SEC_W'(k);
    end
    return r;
  endfunction

  // ---- state ----
  ctl_state_t       st_q, st_d;
  logic [TAG_W-1:0] r_tag;
  logic [IDX_W-1:0] r_idx;
  logic [SEC_W-1:0] r_sec;
  logic [WRD_W-1:0] r_wrd;
  logic             r_write;
  logic [DATA_W-1:0] r_wdata;
  logic [NB-1:0]    r_be;
  logic [WRD_W-1:0] beat_q;

  // ---- named events ----
  logic             accept_evt;
  logic             hit_line;
  logic             sec_hit;
  logic             hit_evt;
  logic             wb_pending;
  logic [SEC_W-1:0] wb_sec;
  logic             beat_last;
  logic             fill_fire;
  logic             wb_fire;
  logic             install_evt;

  assign req_ready   = (st_q == ST_IDLE);
  assign accept_evt  = req_valid && req_ready;
  assign ts_idx      = r_idx;
  assign hit_line    = ts_lvalid && (ts_tag == r_tag);
  assign sec_hit     = hit_line && ts_svalid[r_sec];
  assign hit_evt     = (st_q == ST_LOOK) && sec_hit;
  assign wb_pending  = |ts_sdirty;
  assign wb_sec      = f_first(ts_sdirty);
  assign beat_last   = (beat_q == WRD_W'(SEC_WORDS - 1));
  assign fill_fire   = (st_q == ST_FILL) && mem_ready;
  assign wb_fire     = (st_q == ST_WBACK) && wb_pending && mem_ready;
  assign install_evt = ((st_q == ST_LOOK) && !hit_line && !(ts_lvalid && wb_pending))
                    || ((st_q == ST_WBACK) && !wb_pending);

  // ---- processor side ----
  assign resp_valid = hit_evt;
  assign resp_rdata = ds_rdata;

  // ---- memory side ----
  assign mem_valid = ((st_q == ST_WBACK) && wb_pending) || (st_q == ST_FILL);
  assign mem_write = (st_q == ST_WBACK);
  assign mem_addr  = (st_q == ST_WBACK) ? f_join(ts_tag, r_idx, wb_sec, beat_q)
                                        : f_join(r_tag, r_idx, r_sec, beat_q);
  assign mem_wdata = ds_rdata;

  // ---- data store ports ----
  assign ds_raddr = (st_q == ST_WBACK) ? {r_idx, wb_sec, beat_q} : {r_idx, r_sec, r_wrd};
  assign ds_we    = (hit_evt && r_write) || fill_fire;
  assign ds_waddr = fill_fire ? {r_idx, r_sec, beat_q} : {r_idx, r_sec, r_wrd};
  assign ds_wdata = fill_fire ? mem_rdata : r_wdata;
  assign ds_wbe   = fill_fire ? {NB{1'b1}} : r_be;

  // ---- tag store ports ----
  assign ts_inst_en  = install_evt;
  assign ts_inst_tag = r_tag;
  assign ts_setv     = fill_fire && beat_last;
  assign ts_setd     = hit_evt && r_write;
  assign ts_clrd     = wb_fire && beat_last;
  assign ts_sec      = (st_q == ST_WBACK) ? wb_sec : r_sec;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept_evt) st_d = ST_LOOK;
      ST_LOOK: begin
        if (sec_hit)                      st_d = ST_IDLE;
        else if (hit_line)                st_d = ST_FILL;
        else if (ts_lvalid && wb_pending) st_d = ST_WBACK;
        else                              st_d = ST_FILL;
      end
      ST_WBACK: if (!wb_pending) st_d = ST_FILL;
      ST_FILL:  if (fill_fire && beat_last) st_d = ST_LOOK;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
    end else begin
      st_q <= st_d;
      if (fill_fire || wb_fire) beat_q <= beat_q + WRD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (accept_evt) begin
      r_tag   <= f_tag(req_addr);
      r_idx   <= f_idx(req_addr);
      r_sec   <= f_sec(req_addr);
      r_wrd   <= f_wrd(req_addr);
      r_write <= req_write;
      r_wdata <= req_wdata;
      r_be    <= req_be;
    end
  end

  // ---- assertions ----
  AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> (req_addr[OFF_W-1:0] == '0))
    else $error("misaligned word request"); // R2

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)))
    else $error("memory beat changed while stalled"); // R10

  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> !mem_valid)
    else $error("memory beat during a hit"); // R4

  AST_FILL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |-> (hit_line && !ts_svalid[r_sec]))
    else $error("fill aimed at a present sector or foreign tag"); // R3

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && beat_last) |=> hit_evt)
    else $error("completed fill did not produce a hit"); // R5

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready)
    else $error("ready raised during a response"); // R11

endmodule

// File: rtl/sector_wb_cache.sv
module sector_wb_cache #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LINES     = 64,
  parameter int SECTORS   = 4,
  parameter int SEC_WORDS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  resp_valid,
  output logic [DATA_W-1:0]     resp_rdata,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic                  mem_write,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata
);

  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);
  localparam int WRD_W = $clog2(SEC_WORDS);
  localparam int SEC_W = $clog2(SECTORS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - SEC_W - WRD_W - OFF_W;
  localparam int DEPTH = LINES * SECTORS * SEC_WORDS;
  localparam int DS_AW = IDX_W + SEC_W + WRD_W;

  logic [IDX_W-1:0]   ts_idx;
  logic [TAG_W-1:0]   ts_tag;
  logic               ts_lvalid;
  logic [SECTORS-1:0] ts_svalid;
  logic [SECTORS-1:0] ts_sdirty;
  logic               ts_inst_en;
  logic [TAG_W-1:0]   ts_inst_tag;
  logic               ts_setv;
  logic               ts_setd;
  logic               ts_clrd;
  logic [SEC_W-1:0]   ts_sec;
  logic [DS_AW-1:0]   ds_raddr;
  logic [DATA_W-1:0]  ds_rdata;
  logic               ds_we;
  logic [DS_AW-1:0]   ds_waddr;
  logic [DATA_W-1:0]  ds_wdata;
  logic [NB-1:0]      ds_wbe;

  sc_controller #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES),
    .SECTORS(SECTORS), .SEC_WORDS(SEC_WORDS)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ts_idx(ts_idx), .ts_tag(ts_tag), .ts_lvalid(ts_lvalid),
    .ts_svalid(ts_svalid), .ts_sdirty(ts_sdirty),
    .ts_inst_en(ts_inst_en), .ts_inst_tag(ts_inst_tag),
    .ts_setv(ts_setv), .ts_setd(ts_setd), .ts_clrd(ts_clrd), .ts_sec(ts_sec),
    .ds_raddr(ds_raddr), .ds_rdata(ds_rdata), .ds_we(ds_we),
    .ds_waddr(ds_waddr), .ds_wdata(ds_wdata), .ds_wbe(ds_wbe)
  );

  sc_tag_store #(
    .LINES(LINES), .SECTORS(SECTORS), .TAG_W(TAG_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ts_idx), .rd_tag(ts_tag), .rd_lvalid(ts_lvalid),
    .rd_svalid(ts_svalid), .rd_sdirty(ts_sdirty),
    .inst_en(ts_inst_en), .inst_tag(ts_inst_tag),
    .setv_en(ts_setv), .setd_en(ts_setd), .clrd_en(ts_clrd), .op_sec(ts_sec)
  );

  sc_data_store #(
    .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) u_data (
    .clk(clk),
    .rd_addr(ds_raddr), .rd_data(ds_rdata),
    .wr_en(ds_we), .wr_addr(ds_waddr), .wr_data(ds_wdata), .wr_be(ds_wbe)
  );

endmodule

// File: tb/sector_wb_cache_test.sv
module sector_wb_cache_test;

  localparam int LN = 8;
  localparam int SC = 4;
  localparam int WD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr  = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be    = '0;
  logic        req_ready;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        mem_valid;
  logic        mem_write;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  sector_wb_cache #(.LINES(LN)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // ---- memory contents: device copy and model copy ----
  logic [31:0] dev_mem [bit [31:0]];
  logic [31:0] ref_mem [bit [31:0]];

  function automatic logic [31:0] init_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] dev_rd(input logic [31:0] a);
    if (dev_mem.exists(a)) return dev_mem[a];
    return init_word(a);
  endfunction

  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return init_word(a);
  endfunction

  // ---- behavioural model of the cache ----
  logic [22:0] m_tag [LN];
  bit          m_lv  [LN];
  bit          m_sv  [LN][SC];
  bit          m_sd  [LN][SC];
  logic [31:0] m_dat [LN][SC][WD];

  typedef struct {
    bit          wr;
    logic [31:0] a;
    logic [31:0] d;
    string       rq;
  } beat_t;
  beat_t exp_q[$];

  // R2: tag [31:9], line [8:6], sector [5:4], word [3:2], byte [1:0]
  function automatic logic [31:0] mk(input logic [22:0] t, input int i, input int s, input int w);
    return {t, i[2:0], s[1:0], w[1:0], 2'b00};
  endfunction

  task automatic predict(input bit wr, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, output bit hit, output logic [31:0] rd);
    logic [22:0] t;
    int i, s, w;
    logic [31:0] ad;
    t = a[31:9];
    i = int'(a[8:6]);
    s = int'(a[5:4]);
    w = int'(a[3:2]);
    hit = 1'b0;
    if (m_lv[i] && m_tag[i] == t) begin
      if (m_sv[i][s]) hit = 1'b1;
    end else begin
      if (m_lv[i]) begin
        for (int k = 0; k < SC; k++) begin
          if (m_sd[i][k]) begin
            for (int j = 0; j < WD; j++) begin
              ad = mk(m_tag[i], i, k, j);
              exp_q.push_back('{1'b1, ad, m_dat[i][k][j], "R6"});
              ref_mem[ad] = m_dat[i][k][j];
            end
          end
        end
      end
      m_lv[i] = 1'b1;
      m_tag[i] = t;
      for (int k = 0; k < SC; k++) begin
        m_sv[i][k] = 1'b0;
        m_sd[i][k] = 1'b0;
      end
    end
    if (!hit) begin
      for (int j = 0; j < WD; j++) begin
        ad = mk(t, i, s, j);
        exp_q.push_back('{1'b0, ad, 32'h0, "R3"});
        m_dat[i][s][j] = ref_rd(ad);
      end
      m_sv[i][s] = 1'b1;
    end
    if (wr) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b]) m_dat[i][s][w][b*8 +: 8] = d[b*8 +: 8];
      end
      m_sd[i][s] = 1'b1;
    end
    rd = m_dat[i][s][w];
  endtask

  // ---- memory device and beat comparison, driven away from the active edge ----
  int  ncyc = 0;
  bit  ready_free = 1'b0;

  always @(negedge clk) begin
    beat_t e;
    ncyc++;
    mem_ready = ready_free ? 1'b1 : ((ncyc % 3) != 1);
    mem_rdata = dev_rd(mem_addr);
    if (rst_n && mem_valid && mem_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected memory beat", mem_addr, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(mem_write == e.wr, "R10", "beat direction", 32'(mem_write), 32'(e.wr));
        chk(mem_addr == e.a, e.rq, "beat address", mem_addr, e.a);
        if (e.wr) chk(mem_wdata == e.d, e.rq, "writeback data", mem_wdata, e.d);
      end
      if (mem_write) dev_mem[mem_addr] = mem_wdata;
    end
  end

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input string rq);
    bit hit;
    logic [31:0] exp;
    int cyc;
    predict(wr, a, d, be, hit, exp);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_be    = be;
    chk(req_ready == 1'b1, "R11", "ready while idle", 32'(req_ready), 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!resp_valid && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk(resp_valid == 1'b1, rq, "response arrived", 32'(resp_valid), 32'h1);
    if (hit) chk(cyc == 1, "R1", "hit response latency", 32'(cyc), 32'h1);
    if (!wr) chk(resp_rdata == exp, rq, "read data", resp_rdata, exp);
    chk(exp_q.size() == 0, rq, "memory beats still expected", 32'(exp_q.size()), 32'h0);
    chk(req_ready == 1'b0, "R11", "ready low during response", 32'(req_ready), 32'h0);
  endtask

  localparam logic [31:0] A = 32'h1000_0040;   // line 1, sector 0

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(req_ready == 1'b1, "R12", "req_ready after reset", 32'(req_ready), 32'h1);
    chk(mem_valid == 1'b0, "R12", "mem_valid after reset", 32'(mem_valid), 32'h0);
    chk(resp_valid == 1'b0, "R12", "resp_valid after reset", 32'(resp_valid), 32'h0);

    access(1'b0, A,            32'h0, 4'h0, "R12");  // cold miss, field split R2
    access(1'b0, A + 32'h4,    32'h0, 4'h0, "R1");   // hit
    access(1'b0, A + 32'h14,   32'h0, 4'h0, "R3");   // sector miss, same tag
    access(1'b0, A + 32'h4,    32'h0, 4'h0, "R3");   // sector 0 untouched
    access(1'b1, A + 32'h8,    32'hDEAD_BEEF, 4'b0101, "R4");
    access(1'b0, A + 32'h8,    32'h0, 4'h0, "R4");
    access(1'b1, A + 32'h8,    32'h1122_3344, 4'b1010, "R7");
    access(1'b1, A + 32'hC,    32'h5566_7788, 4'b1111, "R7");
    access(1'b1, A + 32'h34,   32'hCAFE_F00D, 4'b0011, "R5");  // write miss
    access(1'b0, A + 32'h34,   32'h0, 4'h0, "R5");
    access(1'b0, A + 32'h200,  32'h0, 4'h0, "R6");   // evict: sectors 0 and 3 dirty
    access(1'b0, A + 32'h210,  32'h0, 4'h0, "R8");   // other sector of new line absent
    access(1'b0, A,            32'h0, 4'h0, "R9");   // clean eviction
    access(1'b0, A + 32'h18,   32'h0, 4'h0, "R2");

    for (int n = 0; n < 400; n++) begin
      logic [22:0] t;
      int i, s, w;
      if (n == 200) ready_free = 1'b1;
      t = 23'h80 + 23'($urandom_range(2, 0));
      i = int'($urandom_range(LN - 1, 0));
      s = int'($urandom_range(SC - 1, 0));
      w = int'($urandom_range(WD - 1, 0));
      if ($urandom_range(1, 0) == 1)
        access(1'b1, mk(t, i, s, w), $urandom(), 4'($urandom_range(15, 1)), "R7");
      else
        access(1'b0, mk(t, i, s, w), 32'h0, 4'h0, "R6");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule